// File: doc/BRIEF.md
# Protection Fault Status Register

This block gathers the protection events of a backlight driver into one 8-bit sticky status register and an active-low fault flag. The events are per-channel LED open and short detections, a boost output that stays too low for longer than a qualification window, thermal shutdown with a separate recovery threshold, and input undervoltage. From the same state it derives the run enables for the boost converter and for the LED outputs.

Software reads the register to find the cause of a fault. The read strobe clears the latched bits, and so does pulling the enable pin low. The comparators that produce the event inputs lie outside this block. Each event input is a synchronous level, and this block samples it on every clock.

Top module: `fault_status_reg`

## Requirements
- R1: After reset the status reads 0x00, the fault flag is high, and with the enable pin high both run enables are high. Bit positions: 7 open, 6 short, 5 two-or-more channels, 4 exactly one channel, 3 any LED fault, 2 overcurrent, 1 thermal, 0 undervoltage.
- R2: With LED detection enabled, an open on any channel sets bit 7 and a short on any channel sets bit 6, one cycle later. With LED detection disabled, the LED inputs set none of bits 7..3.
- R3: A channel counts as faulty when its open or short input is high. In a cycle with exactly one faulty channel, bits 4 and 3 are set. With two or more faulty channels, bits 5 and 3 are set.
- R4: A set bit stays set after its event goes away. The clock after a read strobe, the register holds only the events present in the read cycle, so an event that coincides with the read stays set.
- R5: While the enable pin is low, the status is held at 0x00 and both run enables are low.
- R6: The fault flag is low exactly when the status is nonzero.
- R7: Bit 2 is set once the low-boost input has been high for more than OCP_TICKS consecutive clocks, which is OCP_TICKS+1 clocks. Any clock with the input low restarts the count. The count is held at zero while bit 2 is set or the enable pin is low.
- R8: While bit 2 is set, the boost enable is low and the LED enable is unaffected. The boost enable returns once bit 2 is cleared.
- R9: An over-temperature trip sets bit 1 and drops both run enables. The enables stay low until the below-recovery input is seen high, even after bit 1 has been cleared. A trip takes priority over recovery in the same cycle.
- R10: With a nonzero undervoltage threshold code, a low input supply sets bit 0 and holds both enables low until the supply indication clears. Threshold code 00 ignores the supply input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_pin | input | 1 | Chip enable; low clears faults and stops outputs |
| rd_strobe | input | 1 | One-cycle pulse when the status register is read |
| led_det_en | input | 1 | Enables LED open/short detection |
| ch_open | input | NUM_CH | Per-channel open-string indication |
| ch_short | input | NUM_CH | Per-channel shorted-string indication |
| boost_low | input | 1 | Boost output below regulation |
| temp_trip | input | 1 | Die temperature at or above shutdown level |
| temp_cool | input | 1 | Die temperature below recovery level |
| uv_code | input | 2 | Undervoltage threshold code, 00 = check off |
| vin_low | input | 1 | Input supply below selected threshold |
| status | output | 8 | Latched fault bits |
| fault_n | output | 1 | Active-low fault flag (open-drain drive level) |
| boost_en | output | 1 | Boost converter run enable |
| led_en | output | 1 | LED output run enable |

## Verification
A corrupted status bit shows at the `status` port and at `fault_n` on the next clock. That is where the bench compares every cycle against its own model. A wrong qualification counter only shows up as an overcurrent bit that arrives one or more clocks early or late, or never arrives. For that reason the window is probed at exactly OCP_TICKS and OCP_TICKS+1 clocks, and across a one-clock break. A thermal state held too long or released too early appears only on the run enables after bit 1 has been cleared, so those are checked after a clearing read.

// File: rtl/fault_status_reg.sv
module fault_status_reg #(
  parameter int NUM_CH    = 4,
  parameter int OCP_TICKS = 250000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_pin,
  input  logic              rd_strobe,
  input  logic              led_det_en,
  input  logic [NUM_CH-1:0] ch_open,
  input  logic [NUM_CH-1:0] ch_short,
  input  logic              boost_low,
  input  logic              temp_trip,
  input  logic              temp_cool,
  input  logic [1:0]        uv_code,
  input  logic              vin_low,
  output logic [7:0]        status,
  output logic              fault_n,
  output logic              boost_en,
  output logic              led_en
);
  localparam int CW = $clog2(OCP_TICKS + 1);
  localparam int NW = $clog2(NUM_CH + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(OCP_TICKS);

  localparam int B_OPEN = 7, B_SHORT = 6, B_MULTI = 5, B_SINGLE = 4;
  localparam int B_ANY = 3, B_OCP = 2, B_TSD = 1, B_UV = 0;

  logic [7:0]        st_q, ev;
  logic [CW-1:0]     ocp_cnt;
  logic              tsd_q, uv_q;
  logic [NUM_CH-1:0] bad_ch;
  logic [NW-1:0]     bad_cnt;

  assign bad_ch = led_det_en ? (ch_open | ch_short) : '0;

  always_comb begin
    bad_cnt = '0;
    for (int i = 0; i < NUM_CH; i++) bad_cnt = bad_cnt + NW'(bad_ch[i]);
  end

  always_comb begin
    ev           = '0;
    ev[B_OPEN]   = led_det_en && (|ch_open);
    ev[B_SHORT]  = led_det_en && (|ch_short);
    ev[B_MULTI]  = bad_cnt > NW'(1);
    ev[B_SINGLE] = bad_cnt == NW'(1);
    ev[B_ANY]    = bad_cnt != '0;
    ev[B_OCP]    = boost_low && !st_q[B_OCP] && (ocp_cnt == CNT_MAX);
    ev[B_TSD]    = temp_trip;
    ev[B_UV]     = (uv_code != 2'b00) && vin_low;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ocp_cnt <= '0;
    else if (!en_pin || !boost_low || st_q[B_OCP])
      ocp_cnt <= '0;
    else if (ocp_cnt != CNT_MAX)
      ocp_cnt <= ocp_cnt + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      st_q <= '0;
    else if (!en_pin)
      st_q <= '0;
    else
      st_q <= (rd_strobe ? 8'h00 : st_q) | ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tsd_q <= 1'b0;
      uv_q  <= 1'b0;
    end else begin
      if (temp_trip)      tsd_q <= 1'b1;
      else if (temp_cool) tsd_q <= 1'b0;
      uv_q <= ev[B_UV];
    end
  end

  assign status   = st_q;
  assign fault_n  = ~(|st_q);
  assign led_en   = en_pin && !tsd_q && !uv_q;
  assign boost_en = led_en && !st_q[B_OCP];

  AST_EN_LOW_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !en_pin |=> (status == 8'h00)); // R5
  AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (en_pin && rd_strobe && ev == 8'h00) |=> (status == 8'h00)); // R4
  AST_BITS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (en_pin && !rd_strobe) |=> ((status & $past(status)) == $past(status))); // R4
  AST_LED_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (en_pin && rd_strobe && !led_det_en) |=> (status[7:3] == 5'b0)); // R2
  AST_OCP_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[B_OCP]) |-> $past(boost_low)); // R7
  AST_TRIP_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (en_pin && temp_trip) |=> (status[B_TSD] && !led_en)); // R9
  AST_UV_OFF_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (en_pin && rd_strobe && uv_code == 2'b00) |=> !status[B_UV]); // R10
endmodule

// File: tb/test_fault_status_reg.sv
`timescale 1ns/1ps
module test_fault_status_reg;
  localparam int NCH = 4;
  localparam int T   = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en, rd, lden, blow, trip, cool, vlow;
  logic [NCH-1:0] op, sh;
  logic [1:0] uvc;
  logic [7:0] status;
  logic fault_n, boost_en, led_en;

  int errors = 0, checks = 0;
  bit done = 0;

  logic [7:0] m_st;
  int m_cnt;
  bit m_tsd, m_uv;

  fault_status_reg #(.NUM_CH(NCH), .OCP_TICKS(T)) i_fault_status_reg (
    .clk(clk), .rst_n(rst_n), .en_pin(en), .rd_strobe(rd), .led_det_en(lden),
    .ch_open(op), .ch_short(sh), .boost_low(blow), .temp_trip(trip),
    .temp_cool(cool), .uv_code(uvc), .vin_low(vlow),
    .status(status), .fault_n(fault_n), .boost_en(boost_en), .led_en(led_en));

  always #2 clk = ~clk;

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] events();
    logic [7:0] e = '0;
    logic [NCH-1:0] bad = lden ? (op | sh) : '0;
    int n = $countones(bad);
    e[7] = lden && (|op);
    e[6] = lden && (|sh);
    e[5] = n >= 2;
    e[4] = n == 1;
    e[3] = n >= 1;
    e[2] = blow && !m_st[2] && (m_cnt == T);
    e[1] = trip;
    e[0] = (uvc != 2'b00) && vlow;
    return e;
  endfunction

  function automatic bit exp_led();
    return en && !m_tsd && !m_uv;
  endfunction

  task automatic model_step();
    logic [7:0] e = events();
    int nc;
    if (!en || !blow || m_st[2]) nc = 0;
    else if (m_cnt != T) nc = m_cnt + 1;
    else nc = m_cnt;
    if (!en) m_st = '0;
    else m_st = (rd ? 8'h00 : m_st) | e;
    if (trip) m_tsd = 1;
    else if (cool) m_tsd = 0;
    m_uv = e[0];
    m_cnt = nc;
  endtask

  task automatic tick();
    model_step();
    @(negedge clk);
  endtask

  task automatic quiet();
    en = 1; rd = 0; lden = 1; op = '0; sh = '0; blow = 0;
    trip = 0; cool = 1; uvc = 2'b01; vlow = 0;
  endtask

  task automatic clear_read();
    rd = 1; tick(); rd = 0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    quiet();
    m_st = '0; m_cnt = 0; m_tsd = 0; m_uv = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", status, 8'h00);
    chk("R1", {7'b0, fault_n}, 8'h01);
    chk("R1", {6'b0, boost_en, led_en}, 8'h03);

    // R2 open on one channel
    op = 4'b0010; tick(); op = '0;
    chk("R2", status, 8'h98);
    // R6 flag follows nonzero status
    chk("R6", {7'b0, fault_n}, 8'h00);
    // R4 sticky after event ends
    tick();
    chk("R4", status, 8'h98);
    clear_read(); tick();
    chk("R4", status, 8'h00);
    chk("R6", {7'b0, fault_n}, 8'h01);

    // R2 detection disabled: ignored
    lden = 0; sh = 4'b1111; op = 4'b0001; tick();
    chk("R2", status, 8'h00);
    sh = '0; op = '0; lden = 1;

    // R3 two channels, mixed open/short
    op = 4'b0001; sh = 4'b0100; tick(); op = '0; sh = '0;
    chk("R3", status, 8'he8);
    clear_read();
    // R3 one channel both open and short
    op = 4'b1000; sh = 4'b1000; tick(); op = '0; sh = '0;
    chk("R3", status, 8'hd8);
    clear_read();

    // R4 event in same cycle as read stays set
    vlow = 1; tick();
    chk("R10", status, 8'h01);
    chk("R10", {6'b0, boost_en, led_en}, 8'h00);
    rd = 1; tick(); rd = 0;
    chk("R4", status, 8'h01);
    vlow = 0; tick();
    chk("R10", {6'b0, boost_en, led_en}, 8'h03);
    chk("R10", status, 8'h01);
    clear_read();
    // R10 threshold off
    uvc = 2'b00; vlow = 1; tick(); tick();
    chk("R10", status, 8'h00);
    chk("R10", {6'b0, boost_en, led_en}, 8'h03);
    vlow = 0; uvc = 2'b11;

    // R5 enable low clears and holds
    op = 4'b0001; tick(); op = '0;
    en = 0; op = 4'b0011; tick();
    chk("R5", status, 8'h00);
    chk("R5", {6'b0, boost_en, led_en}, 8'h00);
    op = '0; en = 1; tick();

    // R7 window: T clocks not enough, T+1 sets
    blow = 1;
    repeat (T) tick();
    chk("R7", status, 8'h00);
    tick();
    chk("R7", status, 8'h04);
    // R8 boost off, LEDs kept
    chk("R8", {6'b0, boost_en, led_en}, 8'h01);
    clear_read();
    chk("R8", {6'b0, boost_en, led_en}, 8'h03);
    blow = 0; tick();
    // R7 break restarts count
    blow = 1; repeat (T) tick();
    blow = 0; tick();
    blow = 1; repeat (T) tick();
    chk("R7", status, 8'h00);
    blow = 0; tick();

    // R9 thermal with hysteretic release
    trip = 1; tick(); trip = 0; cool = 0;
    chk("R9", status, 8'h02);
    chk("R9", {6'b0, boost_en, led_en}, 8'h00);
    clear_read();
    chk("R9", status, 8'h00);
    chk("R9", {6'b0, boost_en, led_en}, 8'h00);
    trip = 1; cool = 1; tick(); trip = 0;
    chk("R9", {6'b0, boost_en, led_en}, 8'h00);
    tick();
    chk("R9", {6'b0, boost_en, led_en}, 8'h03);
    clear_read();

    // constrained random against the model
    for (int k = 0; k < 4000; k++) begin
      en   = ($urandom_range(0, 39) != 0);
      rd   = ($urandom_range(0, 7) == 0);
      lden = ($urandom_range(0, 5) != 0);
      for (int c = 0; c < NCH; c++) begin
        op[c] = ($urandom_range(0, 24) == 0);
        sh[c] = ($urandom_range(0, 24) == 0);
      end
      blow = ($urandom_range(0, 15) != 0);
      trip = ($urandom_range(0, 60) == 0);
      cool = ($urandom_range(0, 3) == 0);
      uvc  = 2'($urandom_range(0, 3));
      vlow = ($urandom_range(0, 29) == 0);
      tick();
      chk("R4", status, m_st);
      chk("R6", {7'b0, fault_n}, {7'b0, m_st == 8'h00});
      chk("R9", {7'b0, led_en}, {7'b0, exp_led()});
      chk("R8", {7'b0, boost_en}, {7'b0, exp_led() && !m_st[2]});
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule